// File: doc/BRIEF.md
# Clock Multiplexer Select and Gate Control Register

This block is the control register for one clock multiplexer that has a gate built in. Software reaches it through a single write port and a combinational read port, using four word addresses. The status word holds a staged parent-select field and an active-low gate bit, and it is read back at its own address. Software changes the status word only through a set address, which ORs in the ones written, and a clear address, which removes the ones written. It never uses a read-modify-write.

The block drives two registered controls toward a glitch-free clock switch: an effective select code and an effective enable. A new staged select value has no effect until software writes the update bit at the update address, and that commit happens only while the gate is open. An update issued while the gate is closed is dropped. Once the gate is opened again, software must issue another update before the staged value reaches the switch.

Top module: `clkmux_ctrl`

## Requirements
- R1: After reset, the status word reads 32'h8000_0000 (select 0, gate bit 31 set), `sel_out` is 0 and `clk_en` is 0.
- R2: A write to address 1 (set) ORs the written data into the implemented status bits on that clock edge. Bits written as zero keep their value.
- R3: A write to address 2 (clear) clears every implemented status bit that is written as one on that clock edge. Bits written as zero keep their value.
- R4: Address 0 returns the staged select in bits [SEL_SHIFT+SEL_W-1:SEL_SHIFT] (bits 2:0 by default) and the gate bit in bit 31. All other bits return zero and cannot be set. Addresses 1, 2 and 3 read as zero.
- R5: `clk_en` is the inverse of the gate bit, delayed by one clock: it changes one edge after the edge that updates the status word.
- R6: A change to the staged select field alone leaves `sel_out` unchanged.
- R7: A write to address 3 with bit 0 (UPD_BIT) set, made while the gate bit is 0, copies the staged select into `sel_out` on that clock edge.
- R8: An update write made while the gate bit is 1 leaves `sel_out` unchanged. Clearing the gate afterwards does not commit the staged value until a new update write arrives.
- R9: A write to address 3 with bit 0 clear has no effect on `sel_out`, whatever the other data bits hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | 2 | Write word address (0 status, 1 set, 2 clear, 3 update) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| sel_out | output | SEL_W | Effective parent select toward the clock switch |
| clk_en | output | 1 | Effective clock enable toward the clock switch |

## Verification
Set writes with overlapping and disjoint patterns show whether ORing leaves zero-written bits alone. Clear writes that cover only part of the select field show the same for removal, and writes to unimplemented bits show that those bits read back as zero. Update writes are tried in three situations: with the gate closed, with the gate open but bit 0 clear and the other bits set, and with the gate open and bit 0 set. Comparing `sel_out` across these cases separates a commit from a dropped or spurious one. A sequence that closes the gate, restages the select, opens the gate and only then updates shows whether a dropped update is wrongly remembered.

// File: rtl/clkmux_pkg.sv
// Package: shared address codes for the clock mux control register.
// Assumes a two-bit word address on both bus ports.
package clkmux_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 2'd0,
        REG_SET    = 2'd1,
        REG_CLEAR  = 2'd2,
        REG_UPDATE = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/clkmux_wdecode.sv
// Module: write decoder. Turns one bus write into a set mask, a clear mask
// and a single-cycle update pulse.
// Assumes at most one write per cycle. The update pulse needs bit UPD_BIT.
module clkmux_wdecode
    import clkmux_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int UPD_BIT = 0
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] set_mask,
    output logic [DATA_W-1:0] clr_mask,
    output logic              upd_fire
);
    reg_addr_e addr_e;
    assign addr_e = reg_addr_e'(wr_addr);

    // Steer write data to the mask that matches the address.
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        upd_fire = 1'b0;
        if (wr_en) begin
            case (addr_e)
                REG_SET:    set_mask = wr_data;
                REG_CLEAR:  clr_mask = wr_data;
                REG_UPDATE: upd_fire = wr_data[UPD_BIT];
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/clkmux_status.sv
// Module: staged status word. Holds the select field and the active-low gate
// bit, and changes them only through the set and clear masks.
// Assumes the gate bit lies outside the select field. Clear wins over set.
module clkmux_status #(
    parameter int DATA_W    = 32,
    parameter int SEL_W     = 3,
    parameter int SEL_SHIFT = 0,
    parameter int GATE_BIT  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_mask,
    input  logic [DATA_W-1:0] clr_mask,
    output logic [SEL_W-1:0]  sel_staged,
    output logic              gate_off,
    output logic [DATA_W-1:0] status_word
);
    logic [SEL_W-1:0] sel_q;
    logic             gate_q;
    logic [SEL_W-1:0] sel_d;
    logic             gate_d;
    logic             unused_mask_bits;

    assign unused_mask_bits = ^{set_mask, clr_mask};

    // Next state: OR in set bits, then remove clear bits.
    always_comb begin
        sel_d  = (sel_q | set_mask[SEL_SHIFT +: SEL_W]) & ~clr_mask[SEL_SHIFT +: SEL_W];
        gate_d = (gate_q | set_mask[GATE_BIT]) & ~clr_mask[GATE_BIT];
    end

    // Hold the staged fields. Reset closes the gate with select zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            gate_q <= 1'b1;
        end else begin
            sel_q  <= sel_d;
            gate_q <= gate_d;
        end
    end

    // Pack the readable word. Unimplemented bits read as zero.
    always_comb begin
        status_word                      = '0;
        status_word[SEL_SHIFT +: SEL_W]  = sel_q;
        status_word[GATE_BIT]            = gate_q;
    end

    assign sel_staged = sel_q;
    assign gate_off   = gate_q;

    assert_set_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask[GATE_BIT] && !clr_mask[GATE_BIT]) |=> gate_q);

    assert_clr_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_mask[GATE_BIT] |=> !gate_q);

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|set_mask) && !(|clr_mask)) |=> ($stable(sel_q) && $stable(gate_q)));
endmodule

// File: rtl/clkmux_commit.sv
// Module: commit stage. Registers the effective select and enable.
// The select moves only on an update pulse while the gate is open. The
// enable follows the gate bit one cycle later. No pending state is kept.
module clkmux_commit #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_staged,
    input  logic             gate_off,
    input  logic             upd_fire,
    output logic [SEL_W-1:0] sel_eff,
    output logic             en_eff
);
    logic [SEL_W-1:0] sel_q;
    logic             en_q;

    // Commit the staged select and track the gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            en_q  <= 1'b0;
        end else begin
            en_q <= ~gate_off;
            if (upd_fire && !gate_off) begin
                sel_q <= sel_staged;
            end
        end
    end

    assign sel_eff = sel_q;
    assign en_eff  = en_q;

    assert_sel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_fire |=> $stable(sel_q));

    assert_gated_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_fire && gate_off) |=> $stable(sel_q));

    assert_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_fire && !gate_off) |=> (sel_q == $past(sel_staged)));

    assert_en_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (en_q == !$past(gate_off)));
endmodule

// File: rtl/clkmux_ctrl.sv
// Module: top of the clock mux control register. Wires decoder, status word
// and commit stage together and serves the read port.
// Assumes one bus write per cycle and a combinational read.
module clkmux_ctrl
    import clkmux_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int SEL_W     = 3,
    parameter int SEL_SHIFT = 0,
    parameter int GATE_BIT  = 31,
    parameter int UPD_BIT   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [SEL_W-1:0]  sel_out,
    output logic              clk_en
);
    logic [DATA_W-1:0] set_mask;
    logic [DATA_W-1:0] clr_mask;
    logic              upd_fire;
    logic [SEL_W-1:0]  sel_staged;
    logic              gate_off;
    logic [DATA_W-1:0] status_word;
    reg_addr_e         rd_e;

    clkmux_wdecode #(.DATA_W(DATA_W), .UPD_BIT(UPD_BIT)) u_dec (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .upd_fire (upd_fire)
    );

    clkmux_status #(
        .DATA_W(DATA_W), .SEL_W(SEL_W), .SEL_SHIFT(SEL_SHIFT), .GATE_BIT(GATE_BIT)
    ) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_mask    (set_mask),
        .clr_mask    (clr_mask),
        .sel_staged  (sel_staged),
        .gate_off    (gate_off),
        .status_word (status_word)
    );

    clkmux_commit #(.SEL_W(SEL_W)) u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_staged (sel_staged),
        .gate_off   (gate_off),
        .upd_fire   (upd_fire),
        .sel_eff    (sel_out),
        .en_eff     (clk_en)
    );

    assign rd_e = reg_addr_e'(rd_addr);

    // Read port: only the status address returns data.
    always_comb begin
        rd_data = '0;
        if (rd_e == REG_STATUS) begin
            rd_data = status_word;
        end
    end

    assert_rd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_e != REG_STATUS) |-> (rd_data == '0));
endmodule

// File: tb/sim_clkmux_ctrl.sv
// Bench: directed scenarios for the clock mux control register.
module sim_clkmux_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [2:0]  sel_out;
    logic        clk_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    clkmux_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sel_out(sel_out), .clk_en(clk_en)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // One write, applied at the next rising edge. Returns at the following negedge.
    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        bus_read(2'd0, v); check("R1 status", v, 32'h8000_0000);
        check("R1 sel_out", {29'd0, sel_out}, 32'd0);
        check("R1 clk_en", {31'd0, clk_en}, 32'd0);
        bus_read(2'd1, v); check("R4 set addr reads 0", v, 32'd0);
        bus_read(2'd2, v); check("R4 clr addr reads 0", v, 32'd0);
    endtask

    task automatic t_set_clear;
        logic [31:0] v;
        bus_write(2'd1, 32'h5);
        bus_read(2'd0, v); check("R2 set 5", v, 32'h8000_0005);
        bus_write(2'd1, 32'h2);
        bus_read(2'd0, v); check("R2 set keeps zero bits", v, 32'h8000_0007);
        bus_write(2'd2, 32'h3);
        bus_read(2'd0, v); check("R3 clear 3", v, 32'h8000_0004);
        bus_write(2'd1, 32'h7FFF_FFF8);
        bus_read(2'd0, v); check("R4 unused bits zero", v, 32'h8000_0004);
        check("R6 staged only", {29'd0, sel_out}, 32'd0);
    endtask

    task automatic t_gated_update;
        logic [31:0] v;
        bus_write(2'd3, 32'h1);
        check("R8 update while gated", {29'd0, sel_out}, 32'd0);
        bus_write(2'd2, 32'h8000_0000);
        bus_read(2'd0, v); check("R3 gate cleared", v, 32'h0000_0004);
        check("R5 enable not yet", {31'd0, clk_en}, 32'd0);
        @(negedge clk);
        check("R5 enable after one cycle", {31'd0, clk_en}, 32'd1);
        check("R8 no carry-over commit", {29'd0, sel_out}, 32'd0);
        bus_write(2'd3, 32'hFFFF_FFFE);
        check("R9 update bit clear", {29'd0, sel_out}, 32'd0);
        bus_read(2'd3, v); check("R4 update addr reads 0", v, 32'd0);
        bus_write(2'd3, 32'h1);
        check("R7 commit after ungate", {29'd0, sel_out}, 32'd4);
    endtask

    task automatic t_restage;
        logic [31:0] v;
        bus_write(2'd2, 32'h7);
        bus_write(2'd1, 32'h3);
        bus_read(2'd0, v); check("R2 restage 3", v, 32'h0000_0003);
        check("R6 output holds", {29'd0, sel_out}, 32'd4);
        bus_write(2'd3, 32'h1);
        check("R7 commit 3", {29'd0, sel_out}, 32'd3);
        bus_write(2'd1, 32'h8000_0000);
        @(negedge clk);
        check("R5 disable after one cycle", {31'd0, clk_en}, 32'd0);
        bus_write(2'd2, 32'h1);
        bus_write(2'd1, 32'h4);
        bus_read(2'd0, v); check("R3 restage 6", v, 32'h8000_0006);
        bus_write(2'd3, 32'h1);
        check("R8 gated update dropped", {29'd0, sel_out}, 32'd3);
        bus_write(2'd2, 32'h8000_0000);
        check("R8 ungate alone", {29'd0, sel_out}, 32'd3);
        bus_write(2'd3, 32'h1);
        check("R7 commit 6", {29'd0, sel_out}, 32'd6);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set_clear();
        t_gated_update();
        t_restage();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule